// File: doc/BRIEF.md
# BCD and Register Block Transfer Sequencer

This block is the memory side of a small byte-oriented processor. It carries out three memory instructions. Each one works relative to a 12-bit index value I that is captured when the instruction starts. The first instruction reads one general register and writes its value to memory as three decimal digits. The second copies registers 0 through X into consecutive memory bytes. The third copies consecutive memory bytes into registers 0 through X.

A single engine drives one byte-wide synchronous memory port and one register-file port. It makes at most one memory access per cycle. The memory returns read data one cycle after it sees the address. The caller pulses a start strobe together with an opcode, a register selector X, the current I and an index-advance mode bit. It then waits for the one-cycle done pulse. When the advance mode is set, a block transfer also hands back an updated index value to be written into I.

Top module: `bcd_xfer_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a start is accepted, busy_o, done_o, mem_we_o, rf_we_o and idx_we_o are all low.
- R2: Opcode 2'b01 (digit split) takes the value of register X and writes its hundreds, tens and units digits, each as a byte 0..9, to addresses I, I+1 and I+2 on three consecutive cycles in that order. For example, 255 gives 2,5,5, 127 gives 1,2,7 and 0 gives 0,0,0.
- R3: Opcode 2'b10 (block store) writes register k to address I+k for k = 0..X, one byte per cycle in ascending order. No other memory byte is written.
- R4: Opcode 2'b11 (block load) reads address I+k into register k for k = 0..X, in ascending order. Registers above X are not written.
- R5: Every memory address is computed modulo 4096, so a transfer that crosses 0xFFF continues at 0x000.
- R6: After a block store or block load with the advance bit set, idx_we_o pulses in the done cycle with the value (I+X+1) mod 4096. When the advance bit is clear, and after a digit split in any case, idx_we_o stays low.
- R7: done_o is high for exactly one cycle, the cycle of the final write. busy_o is high from the cycle after an accepted start up to and including that cycle, and low in the cycle after it.
- R8: A start while busy_o is high is ignored. A start with opcode 2'b00 is ignored and leaves the block idle.
- R9: Counted from the cycle after the start, busy lasts 4 cycles for a digit split, X+1 cycles for a store and X+2 cycles for a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| op_i | input | 2 | Opcode: 01 digit split, 10 block store, 11 block load, 00 none |
| xsel_i | input | 4 | Register selector X |
| idx_i | input | 12 | Index value I at start |
| idx_inc_i | input | 1 | Advance the index after a block transfer |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 12 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 8 | Register-file read data, same cycle |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 8 | Register-file write data |
| idx_we_o | output | 1 | Index update strobe |
| idx_wdata_o | output | 12 | New index value |

## Verification
The checker assumes that the register file answers a read in the same cycle. It also assumes that the memory returns the byte for an address on the next clock edge and that nothing else writes either store while an instruction runs. The bench models both stores as plain arrays and only touches them from the block's write strobes. It pulses start for a single cycle, except in the deliberate overlap test, where the extra strobe falls only in busy cycles. The address-step properties assume that a new instruction cannot begin in a done cycle, and the stimulus always waits for done to fall before the next start.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_BCD   = 2'b01,
    OP_STORE = 2'b10,
    OP_LOAD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BCD_CAP,
    S_BCD_WR,
    S_STORE,
    S_LOAD,
    S_LOAD_TAIL
  } st_e;

endpackage

// File: rtl/bxs_digits.sv
// Binary to packed decimal by shift-and-add-three; the most significant digit sits at the top.
module bxs_digits #(
  parameter int DW   = 8,
  parameter int NDIG = 3
) (
  input  logic [DW-1:0]     bin_i,
  output logic [4*NDIG-1:0] bcd_o
);

  localparam int BW = 4 * NDIG;

  logic [BW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int b = DW - 1; b >= 0; b--) begin
      for (int d = 0; d < NDIG; d++) begin
        if (acc[4*d +: 4] >= 4'd5) acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
      end
      acc = {acc[BW-2:0], bin_i[b]};
    end
    bcd_o = acc;
  end

endmodule

// File: rtl/bxs_wrap_add.sv
// Index plus offset, truncated to the address width (R5: modulo wrap).
module bxs_wrap_add #(
  parameter int AW = 12,
  parameter int OW = 5
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] sum_o
);

  always_comb sum_o = base_i + AW'(off_i);

endmodule

// File: rtl/bxs_engine.sv
module bxs_engine
  import bxs_pkg::*;
#(
  parameter int AW    = 12,
  parameter int CNT_W = 4,
  parameter int NDIG  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  op_e              op_i,
  input  logic [CNT_W-1:0] xsel_i,
  input  logic [AW-1:0]    idx_i,
  input  logic             inc_i,
  output st_e              st_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] x_o,
  output logic [AW-1:0]    base_o,
  output logic             inc_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LAST_DIG = CNT_W'(NDIG - 1);

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] x_q;
  logic [AW-1:0]    base_q;
  logic             inc_q;
  logic             load_en;
  logic             done_c;

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    done_c  = 1'b0;
    case (st_q)
      S_IDLE: begin
        // R8: a start is only seen here, and a null opcode is dropped
        if (start_i && (op_i != OP_NONE)) begin
          load_en = 1'b1;
          cnt_d   = '0;
          case (op_i)
            OP_BCD:   st_d = S_BCD_CAP;
            OP_STORE: st_d = S_STORE;
            default:  st_d = S_LOAD;
          endcase
        end
      end
      S_BCD_CAP: begin
        st_d  = S_BCD_WR;
        cnt_d = '0;
      end
      S_BCD_WR: begin
        if (cnt_q == LAST_DIG) begin
          st_d   = S_IDLE;
          done_c = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_STORE: begin
        if (cnt_q == x_q) begin
          st_d   = S_IDLE;
          done_c = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_LOAD: begin
        if (cnt_q == x_q) st_d = S_LOAD_TAIL;
        else              cnt_d = cnt_q + 1'b1;
      end
      S_LOAD_TAIL: begin
        st_d   = S_IDLE;
        done_c = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // Sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // Instruction operands, captured with an explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      base_q <= '0;
      inc_q  <= 1'b0;
    end else if (load_en) begin
      x_q    <= xsel_i;
      base_q <= idx_i;
      inc_q  <= inc_i;
    end
  end

  assign st_o   = st_q;
  assign cnt_o  = cnt_q;
  assign x_o    = x_q;
  assign base_o = base_q;
  assign inc_o  = inc_q;
  assign done_o = done_c;

endmodule

// File: rtl/bcd_xfer_seq.sv
module bcd_xfer_seq
  import bxs_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 8,
  parameter int NREG = 16,
  parameter int NDIG = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [1:0]              op_i,
  input  logic [$clog2(NREG)-1:0] xsel_i,
  input  logic [AW-1:0]           idx_i,
  input  logic                    idx_inc_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [DW-1:0]           mem_wdata_o,
  output logic                    mem_we_o,
  input  logic [DW-1:0]           mem_rdata_i,
  output logic [$clog2(NREG)-1:0] rf_raddr_o,
  input  logic [DW-1:0]           rf_rdata_i,
  output logic                    rf_we_o,
  output logic [$clog2(NREG)-1:0] rf_waddr_o,
  output logic [DW-1:0]           rf_wdata_o,
  output logic                    idx_we_o,
  output logic [AW-1:0]           idx_wdata_o
);

  localparam int CNT_W = $clog2(NREG);
  localparam int BW    = 4 * NDIG;

  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] xq;
  logic [AW-1:0]    base;
  logic             incq;
  logic             done_c;
  logic [BW-1:0]    split;
  logic [BW-1:0]    digits_q;
  logic [3:0]       digit_sel;
  logic [CNT_W:0]   end_off;
  logic             dig_en;

  bxs_engine #(.AW(AW), .CNT_W(CNT_W), .NDIG(NDIG)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .op_i   (op_e'(op_i)),
    .xsel_i (xsel_i),
    .idx_i  (idx_i),
    .inc_i  (idx_inc_i),
    .st_o   (st),
    .cnt_o  (cnt),
    .x_o    (xq),
    .base_o (base),
    .inc_o  (incq),
    .done_o (done_c)
  );

  bxs_digits #(.DW(DW), .NDIG(NDIG)) u_digits (
    .bin_i(rf_rdata_i),
    .bcd_o(split)
  );

  // R5: every transfer address wraps at the top of the space
  bxs_wrap_add #(.AW(AW), .OW(CNT_W)) u_addr (
    .base_i(base),
    .off_i (cnt),
    .sum_o (mem_addr_o)
  );

  assign end_off = {1'b0, xq} + 1'b1;

  bxs_wrap_add #(.AW(AW), .OW(CNT_W + 1)) u_next_idx (
    .base_i(base),
    .off_i (end_off),
    .sum_o (idx_wdata_o)
  );

  // Digit capture: register X is read during the capture state
  assign dig_en = (st == S_BCD_CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      digits_q <= '0;
    else if (dig_en) digits_q <= split;
  end

  // R2: most significant digit goes to the lowest address
  always_comb begin
    digit_sel = '0;
    for (int g = 0; g < NDIG; g++) begin
      if (cnt == CNT_W'(g)) digit_sel = digits_q[4*(NDIG-1-g) +: 4];
    end
  end

  // Port steering
  always_comb begin
    busy_o      = (st != S_IDLE);
    done_o      = done_c;
    mem_we_o    = (st == S_BCD_WR) || (st == S_STORE);
    mem_wdata_o = (st == S_STORE) ? rf_rdata_i : DW'(digit_sel);
    case (st)
      S_BCD_CAP: rf_raddr_o = xq;
      S_STORE:   rf_raddr_o = cnt;
      default:   rf_raddr_o = '0;
    endcase
    // R4: load writes trail their address by one cycle
    rf_we_o    = ((st == S_LOAD) && (cnt != '0)) || (st == S_LOAD_TAIL);
    rf_waddr_o = (st == S_LOAD_TAIL) ? cnt : (cnt - 1'b1);
    rf_wdata_o = mem_rdata_i;
    // R6: index hand-back only on block transfers with advance set
    idx_we_o   = done_c && incq && ((st == S_STORE) || (st == S_LOAD_TAIL));
  end

endmodule

// File: rtl/bxs_checker.sv
module bxs_checker #(
  parameter int AW  = 12,
  parameter int RAW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [1:0]     op_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           mem_we_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic           rf_we_o,
  input logic [RAW-1:0] rf_waddr_o,
  input logic           idx_we_o
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_we_o && !rf_we_o && !idx_we_o && !done_o));

  p_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && rf_we_o));

  p_mem_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o) && !$past(done_o))
      |-> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  p_rf_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && $past(rf_we_o) && !$past(done_o))
      |-> (rf_waddr_o == $past(rf_waddr_o) + RAW'(1)));

  p_idx_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we_o |-> done_o);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  p_start_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && (op_i != 2'b00)) |=> busy_o);

  p_null_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && (op_i == 2'b00)) |=> !busy_o);

endmodule

bind bcd_xfer_seq bxs_checker #(.AW(AW), .RAW($clog2(NREG))) u_bxs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .op_i      (op_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o),
  .rf_we_o   (rf_we_o),
  .rf_waddr_o(rf_waddr_o),
  .idx_we_o  (idx_we_o)
);

// File: tb/bcd_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module bcd_xfer_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  op_i;
  logic [3:0]  xsel_i;
  logic [11:0] idx_i;
  logic        idx_inc_i;
  logic        busy_o, done_o, mem_we_o, rf_we_o, idx_we_o;
  logic [11:0] mem_addr_o, idx_wdata_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i, rf_rdata_i, rf_wdata_o;
  logic [3:0]  rf_raddr_o, rf_waddr_o;

  logic [7:0] mem [4096];
  logic [7:0] rf  [16];

  typedef struct {int kind; int addr; int data;} item_t;
  item_t q[$];
  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  bcd_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .xsel_i(xsel_i),
    .idx_i(idx_i), .idx_inc_i(idx_inc_i), .busy_o(busy_o), .done_o(done_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
    .mem_rdata_i(mem_rdata_i), .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .idx_we_o(idx_we_o), .idx_wdata_o(idx_wdata_o)
  );

  // Memory and register file models
  assign rf_rdata_i = rf[rf_raddr_o];
  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    mem_rdata_i <= mem[mem_addr_o];
    if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected writes in the order the design produces them
  task automatic take(input int kind, input int addr, input int data);
    item_t e;
    if (q.size() == 0) begin
      chk(1'b0, cur_req, $sformatf("unexpected write kind %0d addr", kind), addr, -1);
    end else begin
      e = q.pop_front();
      chk(e.kind == kind && e.addr == addr && e.data == data, cur_req,
          $sformatf("write kind %0d addr %0h data", kind, addr), data, e.data);
      if (e.addr != addr) chk(1'b0, cur_req, "write address", addr, e.addr);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_we_o) take(0, int'(mem_addr_o), int'(mem_wdata_o));
      if (rf_we_o)  take(1, int'(rf_waddr_o), int'(rf_wdata_o));
      if (idx_we_o) take(2, 0, int'(idx_wdata_o));
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Driver: builds the expected items, starts the instruction and times it
  task automatic run_op(input logic [1:0] op, input int x, input int idx, input bit inc,
                        input string req, input bit intrude);
    int lat;
    int n;
    int v;
    cur_req = req;
    if (op == 2'b01) begin
      v = int'(rf[x]);
      q.push_back('{0, idx % 4096, v / 100});
      q.push_back('{0, (idx + 1) % 4096, (v / 10) % 10});
      q.push_back('{0, (idx + 2) % 4096, v % 10});
      lat = 4;
    end else begin
      for (int k = 0; k <= x; k++) begin
        if (op == 2'b10) q.push_back('{0, (idx + k) % 4096, int'(rf[k])});
        else             q.push_back('{1, k, int'(mem[(idx + k) % 4096])});
      end
      if (inc) q.push_back('{2, 0, (idx + x + 1) % 4096});
      lat = (op == 2'b10) ? x + 1 : x + 2;
    end
    @(negedge clk);
    op_i = op; xsel_i = 4'(x); idx_i = 12'(idx); idx_inc_i = inc; start_i = 1'b1;
    @(negedge clk);
    n = 1;
    start_i = 1'b0;
    if (intrude) begin
      op_i = 2'b11; xsel_i = 4'd0; idx_i = 12'h000; start_i = 1'b1;
    end
    while (!done_o && n < 40) begin
      @(negedge clk);
      n++;
      start_i = 1'b0;
    end
    chk(busy_o == 1'b1, "R7", "busy in done cycle", int'(busy_o), 1);
    chk(n == lat, "R9", "busy length", n, lat);
    start_i = 1'b0;
    @(negedge clk);
    #1;
    chk(done_o == 1'b0 && busy_o == 1'b0, "R7", "done/busy after pulse",
        int'({done_o, busy_o}), 0);
    chk(q.size() == 0, req, "writes still missing", q.size(), 0);
    q.delete();
  endtask

  initial begin
    logic [7:0] keep;
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'b00; xsel_i = '0; idx_i = '0; idx_inc_i = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 7 + 3) & 255);
    for (int i = 0; i < 16; i++)   rf[i]  = 8'(8'h30 + i * 11);
    repeat (3) @(negedge clk);
    #1;
    chk({busy_o, done_o, mem_we_o, rf_we_o, idx_we_o} == 5'b0, "R1", "outputs in reset",
        int'({busy_o, done_o, mem_we_o, rf_we_o, idx_we_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk({busy_o, done_o, mem_we_o, rf_we_o, idx_we_o} == 5'b0, "R1", "outputs after reset",
        int'({busy_o, done_o, mem_we_o, rf_we_o, idx_we_o}), 0);

    // R2 digit split: 255, 127, 0; advance bit must not update the index (R6)
    rf[4] = 8'd255; rf[9] = 8'd127; rf[15] = 8'd0;
    run_op(2'b01, 4, 12'h300, 1'b0, "R2", 1'b0);
    run_op(2'b01, 9, 12'h310, 1'b1, "R2", 1'b0);
    run_op(2'b01, 15, 12'h320, 1'b0, "R2", 1'b0);
    // R5 digit split across the top of memory
    run_op(2'b01, 4, 12'hFFF, 1'b0, "R5", 1'b0);

    // R3 block store, sizes 1, 16 and 6; byte after the block untouched
    for (int i = 0; i < 16; i++) rf[i] = 8'(8'hA0 + i * 5);
    keep = mem[12'h401];
    run_op(2'b10, 0, 12'h400, 1'b0, "R3", 1'b0);
    chk(mem[12'h401] == keep, "R3", "byte past block", int'(mem[12'h401]), int'(keep));
    keep = mem[12'h510];
    run_op(2'b10, 15, 12'h500, 1'b1, "R3", 1'b0);
    chk(mem[12'h510] == keep, "R3", "byte past block", int'(mem[12'h510]), int'(keep));
    run_op(2'b10, 5, 12'h600, 1'b0, "R6", 1'b0);

    // R4 block load, sizes 1, 16 and 8; register past X untouched
    keep = rf[1];
    run_op(2'b11, 0, 12'h123, 1'b0, "R4", 1'b0);
    chk(rf[1] == keep, "R4", "register past X", int'(rf[1]), int'(keep));
    run_op(2'b11, 15, 12'h777, 1'b1, "R4", 1'b0);
    for (int i = 0; i < 16; i++) rf[i] = 8'h5A;
    run_op(2'b11, 7, 12'h040, 1'b0, "R4", 1'b0);
    chk(rf[8] == 8'h5A, "R4", "register past X", int'(rf[8]), 8'h5A);

    // R5 and R6: transfers that wrap past 0xFFF with the index advanced
    run_op(2'b10, 3, 12'hFFE, 1'b1, "R5", 1'b0);
    run_op(2'b11, 5, 12'hFFD, 1'b1, "R5", 1'b0);
    run_op(2'b11, 15, 12'hFF0, 1'b1, "R6", 1'b0);

    // R8: a start during a busy store is ignored
    run_op(2'b10, 5, 12'h800, 1'b0, "R8", 1'b1);

    // R8: null opcode leaves the block idle
    cur_req = "R8";
    @(negedge clk);
    op_i = 2'b00; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy_o == 1'b0, "R8", "busy after null opcode", int'(busy_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule